// File: doc/BRIEF.md
# Default Control Endpoint Status Register (Device Side)

This block holds the byte-wide control and status flags of endpoint zero in a USB device controller. A processor reaches it through a plain register port (write strobe, write data, read data). A protocol engine reports four kinds of events to it: a data packet arrived, an armed packet left, a STALL handshake went out, and the current control transfer terminated. The block drives the transmit-armed and stall-request levels back to the engine, a one-cycle FIFO flush pulse, and a one-cycle interrupt request.

Each flag follows its own rule. Some flags are set by hardware and cleared by software. Others are set by software and cleared by hardware. Two of the flags can only be cleared by writing 1 to a separate strobe bit. The strobe bits hold no state. When a hardware event and a software write target the same flag in the same cycle, the hardware event takes effect. Every flag change shows on the read port in the cycle after the clock edge that caused it.

Top module: `ep0_ctl_csr`

## Requirements
- R1: After reset, every readable bit is 0 and tx_ready, stall_req, fifo_flush and irq are all 0.
- R2: Bit 0 (packet received) is set by ev_rx_pkt. The only way to clear it is a write with bit 6 = 1. Writing bit 0 has no effect.
- R3: Bit 1 (transmit armed) is set by a write with bit 1 = 1 and is cleared by ev_tx_done. Writing 0 to bit 1 has no effect. The tx_ready output equals bit 1.
- R4: Bit 2 (stall sent) is set by ev_stall_sent. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R5: Bit 3 (last data) is set by a write with bit 3 = 1 and is cleared by ev_xfer_end. Writing 0 to bit 3 has no effect.
- R6: If ev_xfer_end arrives while bit 3 reads 0, bit 4 (early end) is set and fifo_flush pulses high for exactly the next cycle. If ev_xfer_end arrives while bit 3 reads 1, bit 4 is not set and fifo_flush stays low. Bit 4 is cleared only by a write with bit 7 = 1.
- R7: Bit 5 (stall request) is set by a write with bit 5 = 1 and is cleared by ev_stall_sent. The stall_req output equals bit 5.
- R8: Bits 7 and 6 always read 0.
- R9: A hardware event on a flag overrides a software write to the same flag in the same cycle. This holds whether the event sets the flag or clears it.
- R10: irq is high in the cycle after ev_rx_pkt, ev_tx_done, or the setting of bit 4, but only if irq_en was 1 in the event cycle. Otherwise irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| irq_en | input | 1 | Interrupt enable for this endpoint |
| ev_rx_pkt | input | 1 | Engine: data packet received |
| ev_tx_done | input | 1 | Engine: armed packet transmitted |
| ev_stall_sent | input | 1 | Engine: STALL handshake transmitted |
| ev_xfer_end | input | 1 | Engine: control transfer terminated |
| tx_ready | output | 1 | Transmit packet armed |
| stall_req | output | 1 | Request to answer with STALL |
| fifo_flush | output | 1 | One-cycle endpoint FIFO flush |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench sweeps every write byte against every combination of the four events, the write strobe and the interrupt enable. It compares each output with a bench model that is built from the rules above.

The sweep covers several corner cases, each tied to a specific failure:
- A design that lets software win a same-cycle conflict would leave bit 0 clear after a service write that coincides with a new packet.
- A design that tests bit 3 after it is cleared, rather than before, would flush the FIFO at the end of a normal transfer.
- A design that treats bit 2 as write-1-to-set would never clear the stall-sent flag.
- A design that ignores irq_en, or that stretches irq past one cycle, would mismatch on the interrupt output.

// File: rtl/ep0_csr_pkg.sv
// Package: bit positions and per-flag policy for the endpoint-zero CSR.
// Assumes flags occupy the low bits and strobes sit above them.
package ep0_csr_pkg;
    localparam int CSR_W      = 8;
    localparam int N_FLAGS    = 6;
    localparam int F_RXRDY    = 0;
    localparam int F_TXRDY    = 1;
    localparam int F_STALLED  = 2;
    localparam int F_LASTDATA = 3;
    localparam int F_EARLYEND = 4;
    localparam int F_STALLREQ = 5;
    localparam int S_SRV_RX   = 6;
    localparam int S_SRV_END  = 7;
    // 1 = hardware sets and software clears; 0 = software sets and hardware clears
    localparam logic [N_FLAGS-1:0] HW_SETS = 6'b010101;
endpackage

// File: rtl/ep0_wr_decode.sv
// Module: turns one register write into per-flag software action strobes.
// Assumes the bit layout in ep0_csr_pkg; a bit whose action is a clear-by-0
// (stall sent) triggers when the written bit is 0.
module ep0_wr_decode
    import ep0_csr_pkg::*;
(
    input  logic             we,
    input  logic [CSR_W-1:0] wd,
    output logic [N_FLAGS-1:0] sw_act
);
    logic unused_wbits;
    assign unused_wbits = ^{wd[F_RXRDY], wd[F_EARLYEND]};

    // Map write data bits to the software action of each flag.
    always_comb begin
        sw_act              = '0;
        sw_act[F_RXRDY]     = we & wd[S_SRV_RX];
        sw_act[F_TXRDY]     = we & wd[F_TXRDY];
        sw_act[F_STALLED]   = we & ~wd[F_STALLED];
        sw_act[F_LASTDATA]  = we & wd[F_LASTDATA];
        sw_act[F_EARLYEND]  = we & wd[S_SRV_END];
        sw_act[F_STALLREQ]  = we & wd[F_STALLREQ];
    end
endmodule

// File: rtl/ep0_flag_cell.sv
// Module: one status flag with a hardware action and a software action.
// HW_SET selects the direction: hardware drives the flag to HW_SET, software
// to its inverse. The hardware action always has priority.
module ep0_flag_cell #(
    parameter bit HW_SET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_act,
    input  logic sw_act,
    output logic q
);
    // Update the flag with hardware priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (hw_act) q <= HW_SET;
        else if (sw_act) q <= ~HW_SET;
    end
endmodule

// File: rtl/ep0_pulse_gen.sv
// Module: registered one-cycle interrupt and FIFO flush pulses.
// Assumes event inputs are single-cycle strobes from the engine.
module ep0_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic rx_evt,
    input  logic tx_evt,
    input  logic early_set,
    output logic irq,
    output logic flush
);
    // Register the pulses so they line up with the flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            flush <= 1'b0;
        end else begin
            irq   <= irq_en & (rx_evt | tx_evt | early_set);
            flush <= early_set;
        end
    end
endmodule

// File: rtl/ep0_ctl_csr.sv
// Module: control/status register of device endpoint zero.
// Combines the write decoder, six flag cells and the pulse generator.
// Assumes engine events are one-cycle strobes synchronous to clk.
module ep0_ctl_csr
    import ep0_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             irq_en,
    input  logic             ev_rx_pkt,
    input  logic             ev_tx_done,
    input  logic             ev_stall_sent,
    input  logic             ev_xfer_end,
    output logic             tx_ready,
    output logic             stall_req,
    output logic             fifo_flush,
    output logic             irq
);
    localparam int PAD_W = CSR_W - N_FLAGS;

    logic [N_FLAGS-1:0] flags;
    logic [N_FLAGS-1:0] sw_act;
    logic [N_FLAGS-1:0] hw_act;
    logic               early_set;

    ep0_wr_decode u_dec (
        .we     (csr_we),
        .wd     (csr_wdata),
        .sw_act (sw_act)
    );

    // Early end is judged on the last-data flag before this edge clears it.
    assign early_set = ev_xfer_end & ~flags[F_LASTDATA];

    // Route engine events to the flag each one acts on.
    always_comb begin
        hw_act              = '0;
        hw_act[F_RXRDY]     = ev_rx_pkt;
        hw_act[F_TXRDY]     = ev_tx_done;
        hw_act[F_STALLED]   = ev_stall_sent;
        hw_act[F_LASTDATA]  = ev_xfer_end;
        hw_act[F_EARLYEND]  = early_set;
        hw_act[F_STALLREQ]  = ev_stall_sent;
    end

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        ep0_flag_cell #(.HW_SET(HW_SETS[i])) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_act (hw_act[i]),
            .sw_act (sw_act[i]),
            .q      (flags[i])
        );
    end

    ep0_pulse_gen u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_en    (irq_en),
        .rx_evt    (ev_rx_pkt),
        .tx_evt    (ev_tx_done),
        .early_set (early_set),
        .irq       (irq),
        .flush     (fifo_flush)
    );

    assign csr_rdata = {{PAD_W{1'b0}}, flags};
    assign tx_ready  = flags[F_TXRDY];
    assign stall_req = flags[F_STALLREQ];
endmodule

// File: rtl/ep0_ctl_csr_chk.sv
// Module: protocol checks for ep0_ctl_csr, attached by bind.
// Assumes it observes the top-level ports only.
module ep0_ctl_csr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csr_we,
    input logic [7:0] csr_wdata,
    input logic [7:0] csr_rdata,
    input logic       irq_en,
    input logic       ev_rx_pkt,
    input logic       ev_tx_done,
    input logic       ev_stall_sent,
    input logic       ev_xfer_end,
    input logic       tx_ready,
    input logic       stall_req,
    input logic       fifo_flush,
    input logic       irq
);
    AST_RX_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ev_rx_pkt && csr_we && csr_wdata[6]) |=> csr_rdata[0]); // R9
    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n) ev_rx_pkt |=> csr_rdata[0]); // R2
    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ev_tx_done |=> !tx_ready); // R3
    AST_STALL_DONE: assert property (@(posedge clk) disable iff (!rst_n) ev_stall_sent |=> (!stall_req && csr_rdata[2])); // R7
    AST_LAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ev_xfer_end |=> !csr_rdata[3]); // R5
    AST_EARLY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) (ev_xfer_end && !csr_rdata[3]) |=> (fifo_flush && csr_rdata[4])); // R6
    AST_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) !(ev_xfer_end && !csr_rdata[3]) |=> !fifo_flush); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |=> !irq); // R10
endmodule

bind ep0_ctl_csr ep0_ctl_csr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq_en(irq_en), .ev_rx_pkt(ev_rx_pkt),
    .ev_tx_done(ev_tx_done), .ev_stall_sent(ev_stall_sent),
    .ev_xfer_end(ev_xfer_end), .tx_ready(tx_ready), .stall_req(stall_req),
    .fifo_flush(fifo_flush), .irq(irq)
);

// File: tb/ep0_ctl_csr_test.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of write byte x events x enable against a model.
module ep0_ctl_csr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       irq_en = 1'b0;
    logic       ev_rx_pkt = 1'b0, ev_tx_done = 1'b0, ev_stall_sent = 1'b0, ev_xfer_end = 1'b0;
    logic       tx_ready, stall_req, fifo_flush, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0] m = '0;
    logic       m_irq = 1'b0, m_flush = 1'b0;

    always #4 clk = ~clk;

    ep0_ctl_csr uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .irq_en(irq_en), .ev_rx_pkt(ev_rx_pkt),
        .ev_tx_done(ev_tx_done), .ev_stall_sent(ev_stall_sent),
        .ev_xfer_end(ev_xfer_end), .tx_ready(tx_ready), .stall_req(stall_req),
        .fifo_flush(fifo_flush), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus and advance the model by the requirements.
    task automatic drive(input bit we, input logic [7:0] wd, input bit rx, input bit txd,
                         input bit ss, input bit xe, input bit ie);
        logic [5:0] n;
        bit early;
        csr_we = we; csr_wdata = wd; ev_rx_pkt = rx; ev_tx_done = txd;
        ev_stall_sent = ss; ev_xfer_end = xe; irq_en = ie;
        early = xe && !m[3];
        n = m;
        if (rx) n[0] = 1'b1; else if (we && wd[6]) n[0] = 1'b0;
        if (txd) n[1] = 1'b0; else if (we && wd[1]) n[1] = 1'b1;
        if (ss) n[2] = 1'b1; else if (we && !wd[2]) n[2] = 1'b0;
        if (xe) n[3] = 1'b0; else if (we && wd[3]) n[3] = 1'b1;
        if (early) n[4] = 1'b1; else if (we && wd[7]) n[4] = 1'b0;
        if (ss) n[5] = 1'b0; else if (we && wd[5]) n[5] = 1'b1;
        m_irq = ie && (rx || txd || early);
        m_flush = early;
        m = n;
        @(negedge clk);
    endtask

    task automatic compare_all();
        chk("R2 rx flag", {7'd0, csr_rdata[0]}, {7'd0, m[0]});
        chk("R3 tx flag", {6'd0, tx_ready, csr_rdata[1]}, {6'd0, m[1], m[1]});
        chk("R4 stall sent", {7'd0, csr_rdata[2]}, {7'd0, m[2]});
        chk("R5 last data", {7'd0, csr_rdata[3]}, {7'd0, m[3]});
        chk("R6 early end/flush", {6'd0, fifo_flush, csr_rdata[4]}, {6'd0, m_flush, m[4]});
        chk("R7 stall req", {6'd0, stall_req, csr_rdata[5]}, {6'd0, m[5], m[5]});
        chk("R8 high bits", {6'd0, csr_rdata[7:6]}, 8'd0);
        chk("R10 irq", {7'd0, irq}, {7'd0, m_irq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk("R1 rdata", csr_rdata, 8'h00);
        chk("R1 outputs", {4'd0, tx_ready, stall_req, fifo_flush, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: new packet and service strobe in the same cycle
        drive(1, 8'h40, 1, 0, 0, 0, 1);
        chk("R9 rx beats service", {7'd0, csr_rdata[0]}, 8'd1);
        chk("R10 irq after rx", {7'd0, irq}, 8'd1);
        drive(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R10 irq one cycle", {7'd0, irq}, 8'd0);
        // R9: arm and transmit-done in the same cycle -> stays clear
        drive(1, 8'h02, 0, 1, 0, 0, 0);
        chk("R9 tx done beats arm", {7'd0, tx_ready}, 8'd0);
        // R6: normal end with last-data set -> no flush, no early-end
        drive(1, 8'h08, 0, 0, 0, 0, 0);
        drive(0, 8'h00, 0, 0, 0, 1, 1);
        chk("R6 normal end no flush", {6'd0, fifo_flush, csr_rdata[4]}, 8'd0);
        // R6: early end flushes and interrupts
        drive(0, 8'h00, 0, 0, 0, 1, 1);
        chk("R6 early end flush", {6'd0, fifo_flush, csr_rdata[4]}, 8'd3);
        chk("R10 irq after early end", {7'd0, irq}, 8'd1);
        // R10: masked interrupt
        drive(0, 8'h00, 1, 0, 0, 0, 0);
        chk("R10 masked", {7'd0, irq}, 8'd0);

        // Exhaustive sweep: write byte x {we, 4 events} x irq_en
        for (int wv = 0; wv < 256; wv++) begin
            for (int ev = 0; ev < 32; ev++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    drive(ev[4], wv[7:0], ev[0], ev[1], ev[2], ev[3], ie[0]);
                    compare_all();
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule